// File: doc/BRIEF.md
# Vibrator Drive Cycle Sequencer

This block turns a level-sensitive enable line into one complete drive cycle for a linear actuator. An accepted rising edge of enable runs a fast start-up phase at full strength. A steady drive phase at the configured strength follows. When enable drops, a brake phase with a configured length starts. The phase code, the strength value and a brake request go to a downstream bridge driver. The bridge driver, resonance tracking and the register bus sit outside this block. Their settings arrive here as plain input fields.

All timing is counted in milliseconds from a tick that divides the system clock. The sequencer protects the actuator in three ways. It ignores enable during a wake-up window after the active-low standby/reset input is released. It keeps a drive going for at least one resonance period, even if enable falls sooner. It holds off a new start until enable has been low for as long as the previous drive lasted, with that wait capped at a parameter (30 ms by default). Any edge that breaks either minimum sets a sticky violation flag.

States: WAKE, IDLE, START, DRIVE, BRAKE and HOLD. HOLD is the lockout after a stop and shows as idle on the phase output. Transitions:
- wake_done: WAKE to IDLE.
- accept: IDLE to START.
- start_done: START to DRIVE.
- stop_brake: START or DRIVE to BRAKE.
- stop_hold: START or DRIVE to HOLD, taken when brake is disabled.
- brake_done: BRAKE to HOLD.
- hold_done: HOLD to IDLE.

Top module: `vib_seq`

## Requirements
- R1: While `rst_n` is low, `phase` is 2'b00 (idle), `drive_lvl` is 0, `brake_req` is 0 and `viol` is 0.
- R2: For WAKE_CYC clock cycles after `rst_n` rises, enable edges start no cycle and set no flag. An enable that is already high when the window ends does not start a cycle; only a later rising edge does.
- R3: A rising edge of `en` seen in IDLE starts the start-up phase: `phase` = 2'b01 and `drive_lvl` = all ones. The configuration inputs are sampled on that same edge.
- R4: Start-up lasts the sampled `start_ms` milliseconds. It is followed by the drive phase, with `phase` = 2'b10 and `drive_lvl` = the sampled `lvl_cfg`. In idle and brake, `drive_lvl` is 0.
- R5: Changes to the configuration inputs after the accepting edge do not affect the running cycle.
- R6: `en` low while running, once at least `per_ms` milliseconds have passed since the start, ends the drive. If `brake_on` was sampled high, the brake phase follows (`phase` = 2'b11, `brake_req` = 1) for `brake_ms` milliseconds.
- R7: If `brake_on` was sampled low, a stop goes straight to `phase` = 2'b00 and `brake_req` stays 0.
- R8: A falling edge of `en` before `per_ms` milliseconds have elapsed does not end the cycle and sets `viol`. The drive continues until the minimum is met, then stops if `en` is still low.
- R9: After a stop, rising edges of `en` are ignored until min(drive length in ms, CAP_MS) milliseconds have passed since the stop. Such an ignored edge sets `viol`.
- R10: `viol` stays set until `rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset and standby |
| en | input | 1 | Level-sensitive drive enable |
| per_ms | input | MS_W | Resonance period in ms; the minimum enable-high time |
| start_ms | input | MS_W | Start-up phase length in ms |
| brake_ms | input | MS_W | Brake phase length in ms |
| lvl_cfg | input | LVL_W | Drive strength for the steady phase |
| brake_on | input | 1 | 1 = brake after a stop, 0 = no brake |
| phase | output | 2 | 00 idle, 01 start-up, 10 drive, 11 brake |
| drive_lvl | output | LVL_W | Strength sent to the bridge driver |
| brake_req | output | 1 | Brake request to the bridge driver |
| viol | output | 1 | Sticky flag for an ignored early enable edge |

## Verification
Two functions can act on the same edge: the end of the minimum-high window and the fall of enable. One is a legal stop and the other is a violation, and the flag must tell them apart. The random cycles often choose a hold time equal to the programmed period, so the fall arrives on the first edge where the elapsed count reaches the minimum. Those cycles must brake without raising the flag. Directed cases put the fall a few milliseconds early, where the drive must continue and the flag must rise. Rising edges are placed just inside the lockout, where they must be ignored, and just after it, where a new start-up must follow.

// File: rtl/vib_seq_pkg.sv
package vib_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_START = 2'b01,
        PH_DRIVE = 2'b10,
        PH_BRAKE = 2'b11
    } phase_t;

    typedef enum logic [2:0] {
        S_WAKE,
        S_IDLE,
        S_START,
        S_DRIVE,
        S_BRAKE,
        S_HOLD
    } state_t;

endpackage

// File: rtl/vib_tick.sv
// Millisecond tick: divides the clock by DIV and can be realigned by restart.
module vib_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign tick = !restart && (cnt == LAST);
endmodule

// File: rtl/vib_satcnt.sv
// Saturating up-counter with synchronous clear.
module vib_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (inc && !(&q))
            q <= q + W'(1);
    end
endmodule

// File: rtl/vib_wake.sv
// Post-reset window during which enable is not observed.
module vib_wake #(
    parameter int CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] DONE = CW'(CYC);

    logic [CW-1:0] cnt;

    assign busy = (cnt != DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (busy)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/vib_seq.sv
module vib_seq
    import vib_seq_pkg::*;
#(
    parameter int TICK_DIV = 50000,
    parameter int WAKE_CYC = 10000,
    parameter int MS_W     = 8,
    parameter int CAP_MS   = 30,
    parameter int LVL_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [MS_W-1:0]  per_ms,
    input  logic [MS_W-1:0]  start_ms,
    input  logic [MS_W-1:0]  brake_ms,
    input  logic [LVL_W-1:0] lvl_cfg,
    input  logic             brake_on,
    output logic [1:0]       phase,
    output logic [LVL_W-1:0] drive_lvl,
    output logic             brake_req,
    output logic             viol
);
    localparam logic [MS_W-1:0] CAP = MS_W'(CAP_MS);

    state_t st, nx;
    phase_t ph;

    logic wake_busy;
    logic tick;
    logic en_q, rise, fall;
    logic running, stopping;
    logic accept, stop_ok, early_fall, early_rise;

    logic [MS_W-1:0]  live_ms, low_ms, need_ms;
    logic [MS_W-1:0]  c_per, c_start, c_brake;
    logic [LVL_W-1:0] c_lvl;
    logic             c_brk;

    // ---- edge detection and event decode ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    assign rise       = en && !en_q;
    assign fall       = !en && en_q;
    assign running    = (st == S_START) || (st == S_DRIVE);
    assign stopping   = (st == S_BRAKE) || (st == S_HOLD);
    assign accept     = (st == S_IDLE) && rise;
    assign stop_ok    = running && !en && (live_ms >= c_per);
    assign early_fall = running && fall && (live_ms < c_per);
    assign early_rise = stopping && rise && (low_ms < need_ms);

    // ---- timing sub-blocks ----
    vib_wake #(.CYC(WAKE_CYC)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (wake_busy)
    );

    vib_tick #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept || stop_ok),
        .tick    (tick)
    );

    // elapsed ms since the accepted start
    vib_satcnt #(.W(MS_W)) u_live (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (tick && running),
        .q     (live_ms)
    );

    // elapsed ms since the stop
    vib_satcnt #(.W(MS_W)) u_low (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stop_ok),
        .inc   (tick && stopping),
        .q     (low_ms)
    );

    // ---- configuration capture and lockout length ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_per   <= '0;
            c_start <= '0;
            c_brake <= '0;
            c_lvl   <= '0;
            c_brk   <= 1'b0;
        end else if (accept) begin
            c_per   <= per_ms;
            c_start <= start_ms;
            c_brake <= brake_ms;
            c_lvl   <= lvl_cfg;
            c_brk   <= brake_on;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            need_ms <= '0;
        else if (stop_ok)
            need_ms <= (live_ms > CAP) ? CAP : live_ms;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            viol <= 1'b0;
        else if (early_fall || early_rise)
            viol <= 1'b1;
    end

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_WAKE;
        else        st <= nx;
    end

    // ---- next state ----
    always_comb begin
        nx = st;
        unique case (st)
            S_WAKE:  if (!wake_busy) nx = S_IDLE;                 // wake_done
            S_IDLE:  if (accept)     nx = S_START;                // accept
            S_START: begin
                if (stop_ok)                nx = c_brk ? S_BRAKE : S_HOLD;
                else if (live_ms >= c_start) nx = S_DRIVE;        // start_done
            end
            S_DRIVE: if (stop_ok) nx = c_brk ? S_BRAKE : S_HOLD;  // stop_brake / stop_hold
            S_BRAKE: if (low_ms >= c_brake) nx = S_HOLD;          // brake_done
            S_HOLD:  if (low_ms >= need_ms) nx = S_IDLE;          // hold_done
            default: nx = S_WAKE;
        endcase
    end

    // ---- outputs ----
    always_comb begin
        ph        = PH_IDLE;
        drive_lvl = '0;
        brake_req = 1'b0;
        unique case (st)
            S_WAKE, S_IDLE, S_HOLD: ph = PH_IDLE;
            S_START: begin
                ph        = PH_START;
                drive_lvl = '1;
            end
            S_DRIVE: begin
                ph        = PH_DRIVE;
                drive_lvl = c_lvl;
            end
            S_BRAKE: begin
                ph        = PH_BRAKE;
                brake_req = 1'b1;
            end
            default: ph = PH_IDLE;
        endcase
    end

    assign phase = ph;
endmodule

// File: rtl/vib_seq_chk.sv
module vib_seq_chk #(
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [1:0]       phase,
    input logic [LVL_W-1:0] drive_lvl,
    input logic             brake_req,
    input logic             viol,
    input logic             wake_busy
);
    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

    // R2
    wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_busy |-> (phase == 2'b00 && !viol));

    // R3
    start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && $past(phase) != 2'b01) |-> $past(en));

    // R6
    brake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && $past(phase) != 2'b11) |-> (!$past(en) && $past(phase) != 2'b00));

    // R7
    brake_req_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brake_req |-> phase == 2'b11);

    // R4
    lvl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 || phase == 2'b11) |-> drive_lvl == '0);

    // R5
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && $past(phase) == 2'b10) |-> $stable(drive_lvl));
endmodule

bind vib_seq vib_seq_chk #(.LVL_W(LVL_W)) u_vib_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .phase     (phase),
    .drive_lvl (drive_lvl),
    .brake_req (brake_req),
    .viol      (viol),
    .wake_busy (wake_busy)
);

// File: tb/test_vib_seq.sv
module test_vib_seq;
    localparam int TD  = 4;
    localparam int WK  = 20;
    localparam int MW  = 8;
    localparam int CAP = 30;
    localparam int LW  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [MW-1:0] per_ms = '0, start_ms = '0, brake_ms = '0;
    logic [LW-1:0] lvl_cfg = '0;
    logic          brake_on = 1'b0;
    logic [1:0]    phase;
    logic [LW-1:0] drive_lvl;
    logic          brake_req, viol;

    int n_cmp = 0;
    int n_bad = 0;
    int wd = 0;
    int m = 0;

    always #10 clk = ~clk;

    vib_seq #(.TICK_DIV(TD), .WAKE_CYC(WK), .MS_W(MW), .CAP_MS(CAP), .LVL_W(LW)) i_vib_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .per_ms(per_ms), .start_ms(start_ms),
        .brake_ms(brake_ms), .lvl_cfg(lvl_cfg), .brake_on(brake_on),
        .phase(phase), .drive_lvl(drive_lvl), .brake_req(brake_req), .viol(viol)
    );

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lockout_ms(int h);
        return (h < CAP) ? h : CAP;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic to_m(int t);
        while (m < t) begin
            @(negedge clk);
            m++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en    = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 phase", 32'(phase), 0);
        chk("R1 drive_lvl", 32'(drive_lvl), 0);
        chk("R1 brake_req", 32'(brake_req), 0);
        chk("R1 viol", 32'(viol), 0);
        rst_n = 1'b1;
        repeat (WK + 5) @(negedge clk);
    endtask

    task automatic set_cfg(int s, int b, int per, bit brk, int lvl);
        start_ms = MW'(s);
        brake_ms = MW'(b);
        per_ms   = MW'(per);
        brake_on = brk;
        lvl_cfg  = LW'(lvl);
    endtask

    task automatic begin_cycle();
        en = 1'b1;
        @(negedge clk);
        m = 0;
    endtask

    // one legal cycle: enable high for h ms (plus half a tick), h >= per
    task automatic run_cycle(int s, int b, int per, int h, bit brk, int lvl);
        int hh;
        int need;
        hh = h * TD + 2;
        need = lockout_ms(h);
        set_cfg(s, b, per, brk, lvl);
        begin_cycle();
        if (s >= 1 && s * TD / 2 < hh - 1) begin
            to_m(s * TD / 2);
            chk("R3 startup phase", 32'(phase), 1);
            chk("R3 startup level", 32'(drive_lvl), 127);
        end
        if (h >= s + 2) begin
            to_m((s * TD + hh) / 2);
            chk("R4 drive phase", 32'(phase), 2);
            chk("R4 drive level", 32'(drive_lvl), 32'(lvl));
            lvl_cfg  = ~LW'(lvl);
            start_ms = 8'hff;
            to_m(m + 1);
            chk("R5 level after cfg change", 32'(drive_lvl), 32'(lvl));
        end
        to_m(hh - 1);
        en = 1'b0;
        if (brk) begin
            if (b >= 1) begin
                to_m(hh + b * TD / 2);
                chk("R6 brake phase", 32'(phase), 3);
                chk("R6 brake_req", 32'(brake_req), 1);
            end
        end else begin
            to_m(hh);
            chk("R7 no-brake phase", 32'(phase), 0);
            chk("R7 no-brake brake_req", 32'(brake_req), 0);
        end
        to_m(hh + max2(b, need) * TD + 3);
        chk("R6 idle after cycle", 32'(phase), 0);
        chk("R8 no violation on legal cycle", 32'(viol), 0);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4211);

        // R2: enable edges during the wake window
        rst_n = 1'b0;
        en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m = 0;
        to_m(3);  en = 1'b1;
        to_m(6);  chk("R2 phase in wake", 32'(phase), 0);
        to_m(8);  en = 1'b0;
        to_m(10); en = 1'b1;
        to_m(30);
        chk("R2 held enable after wake", 32'(phase), 0);
        chk("R2 no flag from wake edges", 32'(viol), 0);
        to_m(31); en = 1'b0;
        to_m(33); en = 1'b1;
        to_m(34); chk("R3 fresh rise after wake", 32'(phase), 1);
        en = 1'b0;
        to_m(80);

        // random legal cycles
        do_reset();
        for (int i = 0; i < 14; i++) begin
            int s, b, per, h, lvl;
            bit brk;
            s   = int'($urandom % 5);
            b   = int'($urandom % 5);
            per = 1 + int'($urandom % 8);
            h   = (($urandom % 3) == 0) ? per : per + int'($urandom % 12);
            brk = 1'($urandom % 2);
            lvl = 1 + int'($urandom % 126);
            run_cycle(s, b, per, h, brk, lvl);
            repeat (3) @(negedge clk);
        end

        // R8: early fall is deferred until the minimum high time
        do_reset();
        set_cfg(1, 2, 10, 1'b1, 5);
        begin_cycle();
        to_m(13); en = 1'b0;
        to_m(16);
        chk("R8 drive continues after early fall", 32'(phase), 2);
        chk("R8 flag after early fall", 32'(viol), 1);
        to_m(44);
        chk("R8 brake once minimum met", 32'(phase), 3);
        to_m(100);
        chk("R10 flag stays set", 32'(viol), 1);

        // R9: lockout equals a short drive time
        do_reset();
        set_cfg(0, 1, 1, 1'b1, 9);
        begin_cycle();
        to_m(49); en = 1'b0;
        to_m(88); chk("R9 no flag before early rise", 32'(viol), 0);
        to_m(90); en = 1'b1;
        to_m(92);
        chk("R9 early rise ignored", 32'(phase), 0);
        chk("R9 early rise flagged", 32'(viol), 1);
        en = 1'b0;
        to_m(100); en = 1'b1;
        to_m(101); chk("R9 rise after lockout accepted", 32'(phase), 1);
        en = 1'b0;
        to_m(160);

        // R9/R7: lockout capped for a long drive, no brake
        do_reset();
        set_cfg(0, 0, 1, 1'b0, 17);
        begin_cycle();
        to_m(161); en = 1'b0;
        to_m(163);
        chk("R7 straight to idle", 32'(phase), 0);
        chk("R7 brake_req low", 32'(brake_req), 0);
        to_m(270); en = 1'b1;
        to_m(272);
        chk("R9 rise inside capped lockout ignored", 32'(phase), 0);
        chk("R9 rise inside capped lockout flagged", 32'(viol), 1);
        en = 1'b0;
        to_m(290); en = 1'b1;
        to_m(291); chk("R9 cap at CAP_MS", 32'(phase), 1);
        en = 1'b0;
        to_m(340);

        // R1: reset in the middle of a drive
        set_cfg(0, 0, 1, 1'b1, 40);
        begin_cycle();
        to_m(10);
        chk("R4 drive before reset", 32'(phase), 2);
        do_reset();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule